// File: doc/BRIEF.md
# Prescaled Interval Timer

This block is an 8-bit interval timer that counts down. A programmable prescaler sets its rate, and it takes part in a small register window on a processor bus. Bus address decoding happens outside the block. The block sees only a timer select strobe, the low address bits, the transfer direction and the write data. The address bits carry the control information in place of data.

- A write with the load bit set stores a new count.
- At the same time, the two low address bits pick a prescale ratio of 1, 8, 64 or 1024.
- Every timer access also sets or clears the interrupt enable, using a separate address bit.

The count is always visible on the read data output. When the count reaches zero, a sticky expired flag is raised. If the interrupt is enabled, the flag also pulls down a shared active-low interrupt request.

After the count wraps past zero, the timer stops using the prescaler and decrements on every clock. Software can then read how far the deadline has been overrun.

Top module: `itmr_top`

## Requirements
- R1: During and after reset: the count is 8'hFF, the prescale ratio is 1024 with the prescale counter full, the interrupt is disabled and the expired flag is clear.
- R2: A timer access with addr[4]=1 and wr=1 loads wdata into the count, and rdata shows it on the next cycle.
- R3: On that load, addr[1:0] selects the prescale ratio: 2'b00 gives 1, 2'b01 gives 8, 2'b10 gives 64 and 2'b11 gives 1024.
- R4: A load restarts the prescaler, so the first decrement comes exactly one full ratio of cycles after the load.
- R5: Outside overrun mode, the count drops by one each time the prescale counter expires, which is once every ratio cycles.
- R6: Every timer access, read or write, sets the interrupt enable to addr[3].
- R7: The expired flag rises on the cycle after rdata first shows zero. It then stays set until the next load.
- R8: irq_n is low exactly when the expired flag is set and the interrupt is enabled.
- R9: A load clears the expired flag on the next cycle.
- R10: Once the count wraps from 0 to 8'hFF, it decrements on every clock until the next load.
- R11: A read access, or a write with addr[4]=0, leaves the count and prescaler running undisturbed. Such a write only updates the interrupt enable.
- R12: A strobe with addr[2]=0 is outside the timer window and has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_sel | input | 1 | Decoded timer strobe, one cycle per access |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 5 | Low address bits: [4] load, [3] interrupt enable, [2] window, [1:0] ratio |
| wdata | input | 8 | Write data (new count) |
| rdata | output | 8 | Current count |
| expired | output | 1 | Timer expired flag |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench targets the following corner cases, and what a faulty design would show for each:

- **Ratio 1:** there is no prescale gap at all. A design that miscounted the reload would stall one cycle per step.
- **First period after a load:** an off-by-one prescaler reload would make the first decrement come early or late.
- **Wrap from zero:** a design that missed overrun mode would keep counting at the prescaled rate after 0 → 8'hFF.
- **Flag clear and enable updates:** a write without the load bit must not reload, and an access outside the window must change nothing. Either fault shows up as a shifted count or a wrong irq_n.
- **Loading zero:** this must raise the flag one cycle after zero appears.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    typedef enum logic [1:0] {
        RATE_1    = 2'b00,
        RATE_8    = 2'b01,
        RATE_64   = 2'b10,
        RATE_1024 = 2'b11
    } rate_e;

    localparam int unsigned NUM_RATES = 4;

endpackage

// File: rtl/itmr_decode.sv
module itmr_decode #(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned LOAD_BIT = 4,
    parameter int unsigned IEN_BIT = 3,
    parameter int unsigned WIN_BIT = 2
) (
    input  logic              tmr_sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              acc,
    output logic              load,
    output logic              ien_val,
    output itmr_pkg::rate_e   load_rate
);
    always_comb begin
        acc       = tmr_sel && addr[WIN_BIT];
        load      = acc && wr && addr[LOAD_BIT];
        ien_val   = addr[IEN_BIT];
        load_rate = itmr_pkg::rate_e'(addr[1:0]);
    end
endmodule

// File: rtl/itmr_prescaler.sv
module itmr_prescaler #(
    parameter int unsigned PRE_W = 10,
    parameter int unsigned SHIFTS [itmr_pkg::NUM_RATES] = '{0, 3, 6, 10}
) (
    input  logic [PRE_W-1:0] pre_q,
    input  itmr_pkg::rate_e  cur_rate,
    input  itmr_pkg::rate_e  load_rate,
    input  logic             load,
    output logic [PRE_W-1:0] pre_d,
    output logic             tick
);
    logic [PRE_W-1:0] reload_tbl [itmr_pkg::NUM_RATES];

    for (genvar g = 0; g < itmr_pkg::NUM_RATES; g++) begin : g_reload
        assign reload_tbl[g] = PRE_W'((64'd1 << SHIFTS[g]) - 64'd1);
    end

    always_comb begin
        tick  = 1'b0;
        if (load) begin
            pre_d = reload_tbl[load_rate];
        end else if (pre_q == '0) begin
            pre_d = reload_tbl[cur_rate];
            tick  = 1'b1;
        end else begin
            pre_d = pre_q - PRE_W'(1);
        end
    end
endmodule

// File: rtl/itmr_top.sv
module itmr_top #(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned PRE_W  = 10,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              expired,
    output logic              irq_n
);
    import itmr_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [PRE_W-1:0] pre;
        rate_e            rate;
        logic             fast;
        logic             flag;
        logic             irq_en;
    } tmr_state_t;

    tmr_state_t s_q, s_d;

    logic             acc, load, ien_val, tick;
    rate_e            load_rate;
    logic [PRE_W-1:0] pre_nxt;
    logic             irq_en_q;

    itmr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .tmr_sel   (tmr_sel),
        .wr        (wr),
        .addr      (addr),
        .acc       (acc),
        .load      (load),
        .ien_val   (ien_val),
        .load_rate (load_rate)
    );

    itmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .pre_q     (s_q.pre),
        .cur_rate  (s_q.rate),
        .load_rate (load_rate),
        .load      (load),
        .pre_d     (pre_nxt),
        .tick      (tick)
    );

    always_comb begin
        s_d     = s_q;
        s_d.pre = pre_nxt;
        if (acc) s_d.irq_en = ien_val;
        if (load) begin
            s_d.count = wdata;
            s_d.rate  = load_rate;
            s_d.fast  = 1'b0;
            s_d.flag  = 1'b0;
        end else begin
            if (s_q.count == '0) s_d.flag = 1'b1;
            if (tick || s_q.fast) begin
                if (s_q.count == '0) s_d.fast = 1'b1;
                s_d.count = s_q.count - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.count  <= '1;
            s_q.pre    <= '1;
            s_q.rate   <= RATE_1024;
            s_q.fast   <= 1'b0;
            s_q.flag   <= 1'b0;
            s_q.irq_en <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_en_q = s_q.irq_en;
    assign rdata    = s_q.count;
    assign expired  = s_q.flag;
    assign irq_n    = ~(s_q.flag & irq_en_q);
endmodule

// File: rtl/itmr_chk.sv
module itmr_chk #(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tmr_sel,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [CNT_W-1:0]  wdata,
    input logic [CNT_W-1:0]  rdata,
    input logic              expired,
    input logic              irq_n
);
    logic ld;
    assign ld = tmr_sel && wr && addr[4] && addr[2];

    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> rdata == $past(wdata));

    // R9
    load_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> !expired);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !ld) |=> expired);

    // R6
    irq_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_sel && addr[2] && !addr[3]) |=> irq_n);

    // R6
    irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_sel && addr[2] && addr[3] && !ld && expired) |=> !irq_n);
endmodule

bind itmr_top itmr_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tmr_sel (tmr_sel),
    .wr      (wr),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .expired (expired),
    .irq_n   (irq_n)
);

// File: tb/itmr_top_tb.sv
module itmr_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tmr_sel = 1'b0;
    logic       wr = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       expired;
    logic       irq_n;

    int n_checks = 0;
    int n_fails  = 0;
    string tag = "R1";

    // reference model state
    int m_count, m_pre, m_ratio;
    bit m_fast, m_flag, m_en;

    always #4 clk = ~clk;

    itmr_top u_dut (
        .clk(clk), .rst_n(rst_n), .tmr_sel(tmr_sel), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .expired(expired), .irq_n(irq_n)
    );

    function automatic int ratio_of(input logic [1:0] code);
        case (code)
            2'b00: return 1;
            2'b01: return 8;
            2'b10: return 64;
            default: return 1024;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_count = 255; m_ratio = 1024; m_pre = 1023;
            m_fast = 0; m_flag = 0; m_en = 0;
        end else if (tmr_sel && addr[2] && wr && addr[4]) begin
            m_en    = addr[3];
            m_count = wdata;
            m_ratio = ratio_of(addr[1:0]);
            m_pre   = m_ratio - 1;
            m_fast  = 0;
            m_flag  = 0;
        end else begin
            bit step;
            if (tmr_sel && addr[2]) m_en = addr[3];
            if (m_count == 0) m_flag = 1;
            step = m_fast || (m_pre == 0);
            m_pre = (m_pre == 0) ? m_ratio - 1 : m_pre - 1;
            if (step) begin
                if (m_count == 0) m_fast = 1;
                m_count = (m_count + 255) % 256;
            end
        end
    end

    task automatic check(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check("rdata", int'(rdata), m_count);
            check("expired", int'(expired), int'(m_flag));
            check("irq_n", int'(irq_n), int'(!(m_flag && m_en)));
        end
    end

    task automatic acc(input logic w, input logic [4:0] a, input logic [7:0] d);
        tmr_sel = 1'b1; wr = w; addr = a; wdata = d;
        @(negedge clk);
        tmr_sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";  idle(20);                        // R1 reset state holds
        tag = "R12"; acc(1'b1, 5'b11000, 8'd77); idle(4); // R12 outside window
        tag = "R3";  acc(1'b1, 5'b11100, 8'd5);  idle(4); // R3 ratio 1, R2 load
        tag = "R7";  idle(10);                        // R7 flag, R8 irq low
        tag = "R10"; idle(270);                       // R10 overrun every clock
        tag = "R9";  acc(1'b1, 5'b10101, 8'd20); idle(2); // R9 flag clear, ratio 8
        tag = "R4";  idle(200);                       // R4 R5 prescaled steps, R8 no irq
        tag = "R6";  acc(1'b0, 5'b01100, 8'd0); idle(3);  // R6 enable by read
        acc(1'b0, 5'b00100, 8'd0); idle(3);               // R6 disable by read
        tag = "R11"; acc(1'b1, 5'b01110, 8'd99); idle(3); // R11 write w/o load bit
        acc(1'b0, 5'b01111, 8'd0); idle(3);               // R11 read undisturbed
        tag = "R5";  acc(1'b1, 5'b11110, 8'd3); idle(300);  // R5 ratio 64
        tag = "R2";  acc(1'b1, 5'b11111, 8'd2); idle(3200); // R2 R3 ratio 1024
        tag = "R7";  acc(1'b1, 5'b10100, 8'd0); idle(6);    // R7 load of zero
        finish_run();
    end
endmodule